// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block runs post-trigger sample capture. Software first sets the configuration inputs and pulses `start`. The sequencer then takes a snapshot of the configuration and arms. A trigger seen while armed starts a programmable delay, counted in clock periods. After the delay the sequencer writes one ADC sample into an on-chip buffer each time the scan-interval down-counter runs out, and it keeps going until the programmed number of samples is stored. Nothing is stored before the trigger.

When capture ends, the sequencer raises a transfer request. Once the request is granted, it streams the stored words out in write order over a valid/ready handshake. A snapshot can allow several triggers, one full acquisition per trigger. In that case the sequencer re-arms after each drain and pulses `done` once after the final word of the final acquisition. Configuration values outside the legal range are forced into range. A sample count larger than the buffer is clipped to the buffer size and flagged.

Top module: `acq_seq`

## Requirements
- R1: During and after reset the block is idle: `busy`, `dma_req`, `dma_valid`, `done`, `buf_we` and `ovf_err` are all 0.
- R2: Configuration inputs are captured only by a `start` pulse taken while idle, and `busy` rises on the next cycle. A trigger before arming has no effect. Changes to the configuration inputs after arming have no effect on the running sequence.
- R3: If a trigger is sampled at clock edge E, the first sample is written at edge E+D, where D is the captured delay. A programmed delay of 0 is used as 1.
- R4: Later samples are written every I clock edges, where I is the captured interval. A programmed interval below 4 is used as 4, so two writes are always at least 4 edges apart.
- R5: Each acquisition writes exactly N samples to buffer addresses 0 to N-1 in order. A programmed count of 0 is used as 1.
- R6: A programmed count above DEPTH is clipped to DEPTH, and `ovf_err` reads 1 from the cycle after that `start` until the next `start`.
- R7: After the last sample, `dma_req` stays high with `dma_valid` low until `dma_gnt` is sampled high. After that, `dma_valid` presents the words in write order, and each word is held stable until `dma_ready` is sampled high.
- R8: Triggers that arrive during delay, capture, request or drain are ignored. They add no samples and start no new acquisition.
- R9: With re-trigger enabled, a snapshot allows max(`cfg_retrig`,1) acquisitions, and the block re-arms after each drain. With re-trigger disabled it allows exactly one.
- R10: `done` is high for exactly one cycle, on the cycle after the final word of the final acquisition is accepted. `busy` is low from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the configuration and arms, when idle |
| trig | input | 1 | Trigger, sampled while armed |
| cfg_interval | input | 32 | Clock edges between samples (minimum 4) |
| cfg_delay | input | 29 | Clock edges from trigger to first sample (minimum 1) |
| cfg_count | input | 32 | Samples per acquisition |
| cfg_retrig_en | input | 1 | Allows more than one trigger per snapshot |
| cfg_retrig | input | 32 | Number of acquisitions when re-trigger is enabled |
| adc_data | input | DW | ADC sample word |
| buf_we | output | 1 | Sample buffer write strobe |
| buf_addr | output | AW | Sample buffer write address |
| buf_wdata | output | DW | Sample buffer write data |
| dma_req | output | 1 | Transfer request |
| dma_gnt | input | 1 | Transfer grant |
| dma_ready | input | 1 | Consumer accepts the current word |
| dma_valid | output | 1 | A word is present on dma_data |
| dma_data | output | DW | Buffer word being drained |
| busy | output | 1 | Not idle |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ovf_err | output | 1 | Last captured count exceeded the buffer |

## Verification
The hardest case to produce from the ports is a trigger that lands while an acquisition is already in its delay, capture or drain phase, combined with a re-trigger sequence whose drain is stalled. The stimulus table includes a row that fires extra trigger pulses two cycles after the real trigger and again during stalled drain cycles. The bench then checks that the sample count and every drained value still match the single accepted trigger. The ADC input carries a free-running cycle number, so each drained word shows the exact edge at which it was captured. This lets delay and interval timing be checked through the transfer port.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int unsigned MIN_INTERVAL = 4;
    localparam int unsigned MIN_DELAY    = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_DELAY,
        S_CAPT,
        S_REQ,
        S_DRAIN
    } acq_state_e;

    typedef struct packed {
        logic [31:0] interval;
        logic [31:0] delay;
        logic [31:0] count;
        logic [31:0] ntrig;
    } acq_cfg_t;

    function automatic logic [31:0] floor_at(input logic [31:0] v, input logic [31:0] lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/acq_buffer.sv
module acq_buffer #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acq_cfg_latch.sv
module acq_cfg_latch
    import acq_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] interval_i,
    input  logic [28:0] delay_i,
    input  logic [31:0] count_i,
    input  logic        retrig_en_i,
    input  logic [31:0] retrig_i,
    output acq_cfg_t    cfg_o,
    output logic        ovf_o
);
    localparam logic [31:0] DEPTH32 = 32'(DEPTH);

    acq_cfg_t nxt;
    logic     too_big;

    always_comb begin
        too_big      = (count_i > DEPTH32);
        nxt.interval = floor_at(interval_i, 32'(MIN_INTERVAL));
        nxt.delay    = floor_at({3'b000, delay_i}, 32'(MIN_DELAY));
        nxt.count    = too_big ? DEPTH32 : floor_at(count_i, 32'd1);
        nxt.ntrig    = retrig_en_i ? floor_at(retrig_i, 32'd1) : 32'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '{interval: 32'(MIN_INTERVAL), delay: 32'(MIN_DELAY),
                       count: 32'd1, ntrig: 32'd1};
            ovf_o <= 1'b0;
        end else if (load) begin
            cfg_o <= nxt;
            ovf_o <= too_big;
        end
    end

endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          trig,
    input  logic [31:0]   cfg_interval,
    input  logic [28:0]   cfg_delay,
    input  logic [31:0]   cfg_count,
    input  logic          cfg_retrig_en,
    input  logic [31:0]   cfg_retrig,
    input  logic [DW-1:0] adc_data,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic [DW-1:0] buf_wdata,
    output logic          dma_req,
    input  logic          dma_gnt,
    input  logic          dma_ready,
    output logic          dma_valid,
    output logic [DW-1:0] dma_data,
    output logic          busy,
    output logic          done,
    output logic          ovf_err
);
    localparam int CW = $clog2(DEPTH + 1);

    acq_state_e    state;
    acq_cfg_t      cfg;
    logic [31:0]   tick;
    logic [31:0]   acq_done_cnt;
    logic [CW-1:0] wcnt;
    logic [CW-1:0] rptr;
    logic [CW-1:0] last_idx;
    logic          arm;
    logic          fire;
    logic          final_acq;

    assign arm       = (state == S_IDLE) && start;
    assign last_idx  = CW'(cfg.count - 32'd1);
    assign fire      = ((state == S_DELAY) || (state == S_CAPT)) && (tick == 32'd1);
    assign final_acq = ((acq_done_cnt + 32'd1) == cfg.ntrig);

    acq_cfg_latch #(.DEPTH(DEPTH)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .load        (arm),
        .interval_i  (cfg_interval),
        .delay_i     (cfg_delay),
        .count_i     (cfg_count),
        .retrig_en_i (cfg_retrig_en),
        .retrig_i    (cfg_retrig),
        .cfg_o       (cfg),
        .ovf_o       (ovf_err)
    );

    acq_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (fire),
        .waddr (wcnt[AW-1:0]),
        .wdata (adc_data),
        .raddr (rptr[AW-1:0]),
        .rdata (dma_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            tick         <= '0;
            wcnt         <= '0;
            rptr         <= '0;
            acq_done_cnt <= '0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state        <= S_ARMED;
                        acq_done_cnt <= '0;
                    end
                end
                S_ARMED: begin
                    if (trig) begin
                        state <= S_DELAY;
                        tick  <= cfg.delay;
                        wcnt  <= '0;
                    end
                end
                S_DELAY, S_CAPT: begin
                    if (tick == 32'd1) begin
                        wcnt  <= wcnt + 1'b1;
                        tick  <= cfg.interval;
                        state <= (wcnt == last_idx) ? S_REQ : S_CAPT;
                    end else begin
                        tick <= tick - 32'd1;
                    end
                end
                S_REQ: begin
                    if (dma_gnt) begin
                        state <= S_DRAIN;
                        rptr  <= '0;
                    end
                end
                S_DRAIN: begin
                    if (dma_ready) begin
                        if (rptr == last_idx) begin
                            acq_done_cnt <= acq_done_cnt + 32'd1;
                            if (final_acq) begin
                                state <= S_IDLE;
                                done  <= 1'b1;
                            end else begin
                                state <= S_ARMED;
                            end
                        end else begin
                            rptr <= rptr + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign buf_we    = fire;
    assign buf_addr  = wcnt[AW-1:0];
    assign buf_wdata = adc_data;
    assign dma_req   = (state == S_REQ);
    assign dma_valid = (state == S_DRAIN);
    assign busy      = (state != S_IDLE);

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          buf_we,
    input logic          dma_req,
    input logic          dma_gnt,
    input logic          dma_valid,
    input logic          dma_ready,
    input logic [DW-1:0] dma_data,
    input logic          busy,
    input logic          done,
    input logic          ovf_err
);
    // R1: an idle block drives no write, request or word
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!buf_we && !dma_req && !dma_valid));

    // R4: two writes are never closer than 4 edges
    p_min_gap_r4: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> !buf_we ##1 !buf_we ##1 !buf_we);

    // R7: a word is held while the consumer stalls
    p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_data)));

    // R7: the drain starts only from a granted request
    p_grant_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_valid) |-> ($past(dma_req) && $past(dma_gnt)));

    // R7: the request stays up until granted
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_gnt) |=> dma_req);

    // R8: no sample writes while transferring
    p_no_write_in_xfer_r8: assert property (@(posedge clk) disable iff (rst)
        (dma_req || dma_valid) |-> !buf_we);

    // R10: done is a single-cycle pulse and comes with the block idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !ovf_err || !busy) ##1 !done);

endmodule

bind acq_seq acq_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .buf_we    (buf_we),
    .dma_req   (dma_req),
    .dma_gnt   (dma_gnt),
    .dma_valid (dma_valid),
    .dma_ready (dma_ready),
    .dma_data  (dma_data),
    .busy      (busy),
    .done      (done),
    .ovf_err   (ovf_err)
);

// File: tb/sim_acq_seq.sv
module sim_acq_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int DEPTH      = 16;
    localparam int AW         = $clog2(DEPTH);
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [31:0] iv;
        logic [31:0] dl;
        logic [31:0] cnt;
        logic        en;
        logic [31:0] nt;
        logic        stall;
        logic        noise;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'd4, 32'd1, 32'd3,  1'b0, 32'd1, 1'b0, 1'b0},
        '{32'd7, 32'd5, 32'd5,  1'b1, 32'd3, 1'b1, 1'b1},
        '{32'd2, 32'd0, 32'd0,  1'b0, 32'd5, 1'b1, 1'b0},
        '{32'd5, 32'd3, 32'd40, 1'b1, 32'd2, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          trig = 1'b0;
    logic [31:0]   cfg_interval = '0;
    logic [28:0]   cfg_delay = '0;
    logic [31:0]   cfg_count = '0;
    logic          cfg_retrig_en = 1'b0;
    logic [31:0]   cfg_retrig = '0;
    logic [DW-1:0] adc_data;
    logic          buf_we;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_wdata;
    logic          dma_req;
    logic          dma_gnt = 1'b0;
    logic          dma_ready = 1'b0;
    logic          dma_valid;
    logic [DW-1:0] dma_data;
    logic          busy;
    logic          done;
    logic          ovf_err;

    int tcnt = 0;
    int we_cnt = 0;
    int addr_err = 0;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 1;
    assign adc_data = tcnt[DW-1:0];

    acq_seq #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .start(start), .trig(trig),
        .cfg_interval(cfg_interval), .cfg_delay(cfg_delay), .cfg_count(cfg_count),
        .cfg_retrig_en(cfg_retrig_en), .cfg_retrig(cfg_retrig), .adc_data(adc_data),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .dma_req(dma_req), .dma_gnt(dma_gnt), .dma_ready(dma_ready),
        .dma_valid(dma_valid), .dma_data(dma_data),
        .busy(busy), .done(done), .ovf_err(ovf_err)
    );

    // write monitor: counts strobes and checks addresses run 0..N-1
    always @(negedge clk) begin
        if (!rst && buf_we) begin
            if (int'(buf_addr) != we_cnt) addr_err++;
            we_cnt++;
        end
    end

    always @(negedge clk) begin
        if (tcnt >= WATCHDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<%0d", tcnt, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_iv(input vec_t v);
        return (v.iv < 4) ? 4 : int'(v.iv);
    endfunction
    function automatic int eff_dl(input vec_t v);
        return (v.dl < 1) ? 1 : int'(v.dl);
    endfunction
    function automatic int eff_cnt(input vec_t v);
        if (v.cnt == 0) return 1;
        if (v.cnt > DEPTH) return DEPTH;
        return int'(v.cnt);
    endfunction
    function automatic int eff_nt(input vec_t v);
        if (!v.en) return 1;
        return (v.nt == 0) ? 1 : int'(v.nt);
    endfunction

    task automatic run_vec(input vec_t v);
        int ei = eff_iv(v);
        int ed = eff_dl(v);
        int ec = eff_cnt(v);
        int en = eff_nt(v);
        int t0;
        int wait_n;
        logic [DW-1:0] held;
        @(negedge clk);
        cfg_interval = v.iv; cfg_delay = v.dl[28:0]; cfg_count = v.cnt;
        cfg_retrig_en = v.en; cfg_retrig = v.nt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(ovf_err == (v.cnt > DEPTH), "R6 ovf_err", ovf_err, (v.cnt > DEPTH));
        // R2: scramble the inputs after arming; the sequence must not notice
        cfg_interval = 32'd11; cfg_delay = 29'd9; cfg_count = 32'd2;
        cfg_retrig_en = ~v.en; cfg_retrig = 32'd6;
        for (int t = 0; t < en; t++) begin
            we_cnt = 0; addr_err = 0;
            t0 = tcnt;
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            if (v.noise) begin
                repeat (2) @(negedge clk);
                trig = 1'b1;   // R8: ignored during delay/capture
                @(negedge clk);
                trig = 1'b0;
            end
            wait_n = 0;
            while (!dma_req && wait_n < 20000) begin
                @(negedge clk);
                wait_n++;
            end
            chk(we_cnt == ec, "R5 sample count", we_cnt, ec);
            chk(addr_err == 0, "R5 address order", addr_err, 0);
            chk(ovf_err == (v.cnt > DEPTH), "R6 ovf_err held", ovf_err, (v.cnt > DEPTH));
            repeat (2) @(negedge clk);
            chk(dma_req && !dma_valid, "R7 request held before grant", {dma_req, dma_valid}, 2);
            dma_gnt = 1'b1;
            @(negedge clk);
            dma_gnt = 1'b0;
            for (int k = 0; k < ec; k++) begin
                longint exp_v = longint'((t0 + ed + k * ei) & ((1 << DW) - 1));
                chk(dma_valid == 1'b1, "R7 valid in drain", dma_valid, 1);
                if (k == 0) chk(dma_data == exp_v, "R3 first sample timing", dma_data, exp_v);
                else        chk(dma_data == exp_v, "R4 sample spacing", dma_data, exp_v);
                if (v.stall && (k % 2 == 0)) begin
                    held = dma_data;
                    if (v.noise) trig = 1'b1;   // R8: ignored during drain
                    @(negedge clk);
                    trig = 1'b0;
                    chk(dma_valid && dma_data == held, "R7 word held on stall", dma_data, held);
                end
                dma_ready = 1'b1;
                @(negedge clk);
                dma_ready = 1'b0;
            end
            chk(done == (t == en - 1), "R10 done on final word", done, (t == en - 1));
            chk(busy == (t != en - 1), "R9 re-arm / idle after drain", busy, (t != en - 1));
            chk(we_cnt == ec, "R8 no extra samples", we_cnt, ec);
            @(negedge clk);
            chk(done == 1'b0, "R10 done one cycle", done, 0);
        end
        // R9: with the allowed triggers used up, a further trigger starts nothing
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R9 no acquisition past trigger budget", busy, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk({busy, dma_req, dma_valid, done, buf_we} == 5'b0, "R1 outputs in reset",
            {busy, dma_req, dma_valid, done, buf_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, dma_req, dma_valid, done, buf_we, ovf_err} == 6'b0, "R1 idle after reset",
            {busy, dma_req, dma_valid, done, buf_we, ovf_err}, 0);
        // R2: trigger before arming
        we_cnt = 0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b0 && we_cnt == 0, "R2 trigger while idle", we_cnt + busy, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R6: a later in-range start clears the overflow flag
        @(negedge clk);
        cfg_count = 32'd2; cfg_interval = 32'd4; cfg_delay = 29'd1; cfg_retrig_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ovf_err == 1'b0, "R6 ovf cleared by next start", ovf_err, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule